// File: doc/BRIEF.md
# Board-Control Interrupt and Status Register Block

This block sits behind a simple register-bus slave. It gathers sixteen level-sensitive interrupt lines from the board into one sticky pending register. A mask register gates that pending register, and the result drives a single interrupt request toward the processor. A line is captured only while its mask bit is already set. Once captured, the bit stays set until software rewrites the pending register.

The same address space holds eight plain read/write scratch and control words: two LED data words, an LED control word, a switch word, three miscellaneous write words and a miscellaneous read word. It also holds two card-slot status words. Two of the interrupt lines also drive an active-low card-detect flag in these status words. Software may rewrite only the five low bits of a slot word.

Reads are registered: the data for a read issued in one cycle appears on `bus_rdata` after the following rising edge and holds until the next read. The asynchronous active-low reset is released through a two-stage synchronizer, so the registers leave reset two clock edges after `rst_n` rises.

Top module: `brd_ctl_regs`

## Requirements
- R1: After reset, the scratch words, the mask and the pending register read 0, both slot words read 0x00000420 (bit 10 ready, bit 5 card absent), and `irq_out` is low.
- R2: The scratch words at byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 each store a full 32-bit write. A read with `bus_rd` high returns the stored value on `bus_rdata` one cycle later.
- R3: A write to the mask at 0xC0 stores the write data ANDed with 0x000FEEFF, so bits 8, 12 and 20 to 31 read 0.
- R4: A write to the pending register at 0xD0 replaces it with the write data ANDed with 0x000FEEFF. Writing 0 to a bit clears it, and writing 1 to a bit sets it.
- R5: Pending bit i is set at a clock edge where `irq_in[i]` is high and mask bit i is already set. The bit stays set after the line falls. A line that is high while its mask bit is clear leaves no trace.
- R6: `irq_out` is high exactly when some bit is set in both the pending register and the mask register. It reflects a mask or pending write from the cycle after that write.
- R7: Bit 5 of slot 0 (offset 0xE0) is the inverse of `irq_in[9]`, and bit 5 of slot 1 (offset 0xE4) is the inverse of `irq_in[13]`. Each bit is sampled at every clock edge.
- R8: A write to a slot word changes only bits [4:0]. All other bits keep their value.
- R9: A read of any offset not listed above returns 0. A write to such an offset changes no register.
- R10: When an input sets a pending bit in the same cycle as a software write to the pending register, that bit ends up set, whatever the write data holds for it.
- R11: When a card-detect line changes in the same cycle as a write to its slot word, bit 5 follows the line and bits [4:0] take the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | DW (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW (32) | Registered read data |
| irq_in | input | NUM_IRQ (16) | Level interrupt lines from the board |
| irq_out | output | 1 | Combined masked interrupt request |

## Verification
Two pairs of events can meet on one clock edge. An interrupt line can set a pending bit while software rewrites the pending register, and a card-detect line can toggle while software writes that slot word. The bench raises the line and the write strobe on the same falling edge, so both reach the same rising edge. It then reads the register back. The input-set bit must survive a zero write, and the slot word must show the new detect level together with the written low bits.

// File: rtl/brd_ctl_pkg.sv
package brd_ctl_pkg;

  localparam int unsigned NUM_SCRATCH  = 8;
  localparam int unsigned NUM_SLOTS    = 2;
  localparam int unsigned SLOT_WR_BITS = 5;
  localparam int unsigned SLOT_CD_BIT  = 5;

  localparam logic [7:0]  OFF_MASK     = 8'hC0;
  localparam logic [7:0]  OFF_PEND     = 8'hD0;
  localparam logic [31:0] IRQ_KEEP     = 32'h000F_EEFF;
  localparam logic [31:0] SLOT_RST_VAL = 32'h0000_0420;

  // byte offset of each plain scratch/control word
  function automatic logic [7:0] scratch_off(input int unsigned idx);
    logic [7:0] off;
    case (idx)
      0:       off = 8'h10;
      1:       off = 8'h14;
      2:       off = 8'h40;
      3:       off = 8'h60;
      4:       off = 8'h80;
      5:       off = 8'h84;
      6:       off = 8'h88;
      default: off = 8'h90;
    endcase
    return off;
  endfunction

  function automatic logic [7:0] slot_off(input int unsigned idx);
    return 8'hE0 + 8'(idx * 4);
  endfunction

  // interrupt line that also reports card presence for a slot
  function automatic int unsigned slot_cd_irq(input int unsigned idx);
    return (idx == 0) ? 9 : 13;
  endfunction

  function automatic logic is_mapped(input logic [7:0] a);
    logic hit;
    hit = (a == OFF_MASK) || (a == OFF_PEND);
    for (int unsigned i = 0; i < NUM_SCRATCH; i++) hit = hit || (a == scratch_off(i));
    for (int unsigned j = 0; j < NUM_SLOTS; j++)   hit = hit || (a == slot_off(j));
    return hit;
  endfunction

endpackage

// File: rtl/brd_rst_sync.sv
module brd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_nxt;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/brd_scratch_bank.sv
module brd_scratch_bank #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         wr_en,
  input  logic [DW-1:0]        wdata,
  output logic [N-1:0][DW-1:0] regs_q
);

  for (genvar g = 0; g < N; g++) begin : g_word
    logic [DW-1:0] word_q;
    logic [DW-1:0] word_nxt;
    logic          word_en;

    always_comb begin
      word_en  = wr_en[g];
      word_nxt = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_nxt;
    end

    assign regs_q[g] = word_q;
  end

endmodule

// File: rtl/brd_irq_ctl.sv
module brd_irq_ctl
  import brd_ctl_pkg::*;
#(
  parameter int unsigned NIRQ = 16,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_wr,
  input  logic            pend_wr,
  input  logic [DW-1:0]   wdata,
  input  logic [NIRQ-1:0] irq_in,
  output logic [DW-1:0]   mask_q,
  output logic [DW-1:0]   pend_q,
  output logic            irq_out
);

  localparam logic [DW-1:0] KEEP = DW'(IRQ_KEEP);

  logic [DW-1:0] line_wide;
  logic [DW-1:0] line_hit;
  logic [DW-1:0] mask_nxt;
  logic [DW-1:0] pend_base;
  logic [DW-1:0] pend_nxt;

  always_comb begin
    line_wide = '0;
    line_wide[NIRQ-1:0] = irq_in;
    // capture only through a mask bit that is already set
    line_hit  = line_wide & mask_q & KEEP;
    mask_nxt  = wdata & KEEP;
    pend_base = pend_wr ? (wdata & KEEP) : pend_q;
    // hardware set wins over a same-cycle software clear
    pend_nxt  = pend_base | line_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

  assign irq_out = |(pend_q & mask_q);

endmodule

// File: rtl/brd_slot_stat.sv
module brd_slot_stat #(
  parameter int unsigned DW      = 32,
  parameter int unsigned WR_BITS = 5,
  parameter int unsigned CD_BIT  = 5,
  parameter logic [31:0] RST_VAL = 32'h0000_0420
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WR_BITS-1:0] wr_bits,
  input  logic               cd_level,
  output logic [DW-1:0]      stat_q
);

  logic [DW-1:0] stat_nxt;

  always_comb begin
    stat_nxt = stat_q;
    if (wr_en) stat_nxt[WR_BITS-1:0] = wr_bits;
    // active-low presence flag follows the line every cycle
    stat_nxt[CD_BIT] = ~cd_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= DW'(RST_VAL);
    else        stat_q <= stat_nxt;
  end

endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
  import brd_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               bus_rd,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               irq_out
);

  logic                           rst_sync_n;
  logic [NUM_SCRATCH-1:0]         scr_hit;
  logic [NUM_SLOTS-1:0]           slot_hit;
  logic                           mask_hit;
  logic                           pend_hit;
  logic [NUM_SCRATCH-1:0][DW-1:0] scr_q;
  logic [NUM_SLOTS-1:0][DW-1:0]   slot_stat;
  logic [NUM_SLOTS-1:0]           slot_cd;
  logic [DW-1:0]                  mask_q;
  logic [DW-1:0]                  pend_q;
  logic [DW-1:0]                  rd_mux;
  logic [DW-1:0]                  rdata_q;
  logic [DW-1:0]                  rdata_nxt;

  brd_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  // address decode
  always_comb begin
    mask_hit = (bus_addr == ADDR_W'(OFF_MASK));
    pend_hit = (bus_addr == ADDR_W'(OFF_PEND));
    for (int unsigned i = 0; i < NUM_SCRATCH; i++)
      scr_hit[i] = (bus_addr == ADDR_W'(scratch_off(i)));
    for (int unsigned j = 0; j < NUM_SLOTS; j++)
      slot_hit[j] = (bus_addr == ADDR_W'(slot_off(j)));
  end

  brd_scratch_bank #(.N(NUM_SCRATCH), .DW(DW)) u_scratch (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (scr_hit & {NUM_SCRATCH{bus_wr}}),
    .wdata  (bus_wdata),
    .regs_q (scr_q)
  );

  brd_irq_ctl #(.NIRQ(NUM_IRQ), .DW(DW)) u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mask_wr (bus_wr & mask_hit),
    .pend_wr (bus_wr & pend_hit),
    .wdata   (bus_wdata),
    .irq_in  (irq_in),
    .mask_q  (mask_q),
    .pend_q  (pend_q),
    .irq_out (irq_out)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_cd[s] = irq_in[slot_cd_irq(s)];

    brd_slot_stat #(
      .DW      (DW),
      .WR_BITS (SLOT_WR_BITS),
      .CD_BIT  (SLOT_CD_BIT),
      .RST_VAL (SLOT_RST_VAL)
    ) u_stat (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_en    (bus_wr & slot_hit[s]),
      .wr_bits  (bus_wdata[SLOT_WR_BITS-1:0]),
      .cd_level (slot_cd[s]),
      .stat_q   (slot_stat[s])
    );
  end

  // read mux: unmapped offsets fall through to zero
  always_comb begin
    rd_mux = '0;
    for (int unsigned i = 0; i < NUM_SCRATCH; i++)
      if (scr_hit[i]) rd_mux = scr_q[i];
    for (int unsigned j = 0; j < NUM_SLOTS; j++)
      if (slot_hit[j]) rd_mux = slot_stat[j];
    if (mask_hit) rd_mux = mask_q;
    if (pend_hit) rd_mux = pend_q;
  end

  always_comb begin
    rdata_nxt = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (bus_rd)  rdata_q <= rdata_nxt;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/brd_ctl_regs_chk.sv
module brd_ctl_regs_chk
  import brd_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DW     = 32,
  parameter int unsigned NIRQ   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [NIRQ-1:0]   irq_in,
  input logic              irq_out,
  input logic [DW-1:0]     mask_q,
  input logic [DW-1:0]     pend_q,
  input logic [DW-1:0]     slot0_q,
  input logic [DW-1:0]     slot1_q
);

  localparam logic [DW-1:0] KEEP = DW'(IRQ_KEEP);

  logic [DW-1:0] line_wide;
  logic [DW-1:0] line_hit;
  logic          mask_sel;
  logic          pend_sel;
  logic          unmapped;

  always_comb begin
    line_wide = '0;
    line_wide[NIRQ-1:0] = irq_in;
    line_hit = line_wide & mask_q & KEEP;
    mask_sel = (bus_addr == ADDR_W'(OFF_MASK));
    pend_sel = (bus_addr == ADDR_W'(OFF_PEND));
    unmapped = ((bus_addr >> 8) != '0) || !is_mapped(bus_addr[7:0]);
  end

  // R3
  a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && mask_sel) |=> (mask_q == ($past(bus_wdata) & KEEP)));

  // R5
  a_r5_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && pend_sel) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R10
  a_r10_set_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (line_hit != '0) |=> ((pend_q & $past(line_hit)) == $past(line_hit)));

  // R6
  a_r6_mask_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && mask_sel && (bus_wdata == '0)) |=> !irq_out);

  // R7
  a_r7_slot0_detect: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (slot0_q[SLOT_CD_BIT] == !$past(irq_in[slot_cd_irq(0)])));

  // R7
  a_r7_slot1_detect: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (slot1_q[SLOT_CD_BIT] == !$past(irq_in[slot_cd_irq(1)])));

  // R8
  a_r8_slot_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (slot0_q[DW-1:SLOT_CD_BIT+1] == $past(slot0_q[DW-1:SLOT_CD_BIT+1])));

  // R9
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && unmapped) |=> (bus_rdata == '0));

endmodule

bind brd_ctl_regs brd_ctl_regs_chk #(
  .ADDR_W (ADDR_W),
  .DW     (DW),
  .NIRQ   (NUM_IRQ)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_in    (irq_in),
  .irq_out   (irq_out),
  .mask_q    (mask_q),
  .pend_q    (pend_q),
  .slot0_q   (slot_stat[0]),
  .slot1_q   (slot_stat[1])
);

// File: tb/brd_ctl_regs_test.sv
`timescale 1ns/1ps
module brd_ctl_regs_test;

  localparam logic [31:0] KEEP = 32'h000F_EEFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic [15:0] irq_in;
  logic        irq_out;

  int total = 0;
  int bad   = 0;

  logic [7:0] scr_offs [8] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90};

  always #2.5 clk = ~clk;

  brd_ctl_regs uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .irq_out   (irq_out)
  );

  function automatic logic tb_mapped(input logic [7:0] a);
    logic hit;
    hit = (a == 8'hC0) || (a == 8'hD0) || (a == 8'hE0) || (a == 8'hE4);
    for (int i = 0; i < 8; i++) hit = hit || (a == scr_offs[i]);
    return hit;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_lines(input logic [15:0] m);
    @(negedge clk);
    irq_in = m;
    @(negedge clk);
    irq_in = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0; irq_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    chk("R1 irq_out", {31'd0, irq_out}, 32'd0);
    for (int i = 0; i < 8; i++) begin bus_read(scr_offs[i], rv); chk("R1 scratch", rv, 32'd0); end
    bus_read(8'hC0, rv); chk("R1 mask", rv, 32'd0);
    bus_read(8'hD0, rv); chk("R1 pending", rv, 32'd0);
    bus_read(8'hE0, rv); chk("R1 slot0", rv, 32'h420);
    bus_read(8'hE4, rv); chk("R1 slot1", rv, 32'h420);

    // R2 scratch store and read back
    for (int i = 0; i < 8; i++) bus_write(scr_offs[i], 32'hA55A_0000 ^ (32'h0101_0101 * (i + 1)));
    for (int i = 0; i < 8; i++) begin
      bus_read(scr_offs[i], rv);
      chk("R2 scratch", rv, 32'hA55A_0000 ^ (32'h0101_0101 * (i + 1)));
    end

    // R3 mask filtering
    for (int k = 0; k < 4; k++) begin
      logic [31:0] pat;
      pat = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h0000_1100 : (k == 2) ? 32'h5A5A_5A5A : 32'h000F_EEFF;
      bus_write(8'hC0, pat);
      bus_read(8'hC0, rv); chk("R3 mask", rv, pat & KEEP);
    end
    bus_write(8'hC0, 32'd0);

    // R4 pending replace, set and clear
    bus_write(8'hD0, 32'hFFFF_FFFF);
    bus_read(8'hD0, rv); chk("R4 pending set", rv, KEEP);
    bus_write(8'hD0, 32'h0000_0F0F);
    bus_read(8'hD0, rv); chk("R4 pending replace", rv, 32'h0000_0F0F & KEEP);
    bus_write(8'hD0, 32'd0);
    bus_read(8'hD0, rv); chk("R4 pending clear", rv, 32'd0);

    // R5 per-line latch sweep with everything unmasked
    bus_write(8'hC0, 32'hFFFF_FFFF);
    for (int i = 0; i < 16; i++) begin
      bus_write(8'hD0, 32'd0);
      pulse_lines(16'(1 << i));
      chk("R5/R6 irq_out after pulse", {31'd0, irq_out}, {31'd0, (((32'd1 << i) & KEEP) != 0)});
      bus_read(8'hD0, rv);
      chk("R5 sticky pending", rv, (32'd1 << i) & KEEP);
    end
    // R5 masked lines leave nothing
    bus_write(8'hC0, 32'd0);
    bus_write(8'hD0, 32'd0);
    pulse_lines(16'hFFFF);
    bus_write(8'hC0, 32'hFFFF_FFFF);
    bus_read(8'hD0, rv); chk("R5 masked no latch", rv, 32'd0);
    chk("R5 masked irq_out", {31'd0, irq_out}, 32'd0);

    // R6 output follows pending AND mask
    bus_write(8'hC0, 32'd0);
    bus_write(8'hD0, 32'h4);
    chk("R6 masked pending", {31'd0, irq_out}, 32'd0);
    bus_write(8'hC0, 32'h4);
    chk("R6 unmask raises", {31'd0, irq_out}, 32'd1);
    bus_write(8'hC0, 32'h0);
    chk("R6 mask drops", {31'd0, irq_out}, 32'd0);
    bus_write(8'hC0, 32'h100);
    bus_write(8'hD0, 32'h100);
    chk("R6 dead bit 8", {31'd0, irq_out}, 32'd0);

    // R7 card-detect tracking
    bus_write(8'hC0, 32'd0);
    bus_write(8'hD0, 32'd0);
    @(negedge clk); irq_in = 16'h0200;
    bus_read(8'hE0, rv); chk("R7 slot0 present", rv, 32'h400);
    bus_read(8'hE4, rv); chk("R7 slot1 absent", rv, 32'h420);
    @(negedge clk); irq_in = 16'h2000;
    bus_read(8'hE0, rv); chk("R7 slot0 absent", rv, 32'h420);
    bus_read(8'hE4, rv); chk("R7 slot1 present", rv, 32'h400);
    @(negedge clk); irq_in = 16'h0000;

    // R8 only low five bits writable
    bus_write(8'hE0, 32'hFFFF_FFFF);
    bus_read(8'hE0, rv); chk("R8 slot0 all ones", rv, 32'h43F);
    bus_write(8'hE4, 32'h0000_0012);
    bus_read(8'hE4, rv); chk("R8 slot1 pattern", rv, 32'h432);
    bus_write(8'hE0, 32'h0000_0000);
    bus_read(8'hE0, rv); chk("R8 slot0 zero", rv, 32'h420);

    // R9 unmapped sweep
    bus_write(8'hC0, 32'h0000_0003);
    bus_write(8'hD0, 32'h0000_0001);
    for (int a = 0; a < 256; a += 4) begin
      if (!tb_mapped(8'(a))) begin
        bus_write(8'(a), 32'hFFFF_FFFF);
        bus_read(8'(a), rv);
        chk("R9 unmapped read", rv, 32'd0);
      end
    end
    for (int i = 0; i < 8; i++) begin
      bus_read(scr_offs[i], rv);
      chk("R9 scratch untouched", rv, 32'hA55A_0000 ^ (32'h0101_0101 * (i + 1)));
    end
    bus_read(8'hC0, rv); chk("R9 mask untouched", rv, 32'h3);
    bus_read(8'hD0, rv); chk("R9 pending untouched", rv, 32'h1);
    bus_read(8'hE4, rv); chk("R9 slot1 untouched", rv, 32'h432);

    // R10 input set collides with a clearing write
    bus_write(8'hC0, 32'hFFFF_FFFF);
    bus_write(8'hD0, 32'h0000_0008);
    @(negedge clk);
    irq_in = 16'h0004; bus_addr = 8'hD0; bus_wdata = 32'd0; bus_wr = 1'b1;
    @(negedge clk);
    irq_in = '0; bus_wr = 1'b0;
    bus_read(8'hD0, rv); chk("R10 input wins", rv, 32'h4);
    chk("R10 irq_out", {31'd0, irq_out}, 32'd1);
    bus_write(8'hC0, 32'd0);
    bus_write(8'hD0, 32'd0);

    // R11 detect change collides with a slot write
    @(negedge clk);
    irq_in = 16'h2000; bus_addr = 8'hE4; bus_wdata = 32'h0000_0015; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_read(8'hE4, rv); chk("R11 slot1 merge", rv, 32'h415);
    @(negedge clk);
    irq_in = 16'h0000; bus_addr = 8'hE4; bus_wdata = 32'h0000_000A; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_read(8'hE4, rv); chk("R11 slot1 release", rv, 32'h42A);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule